// File: doc/BRIEF.md
# Slot-Timed ADC Range Controller

This block sits beside an ADC input and steers an external RF attenuator or VGA so that the converter output stays inside a target amplitude band. It keeps an 8-bit attenuation level. The top three bits of that level select 6, 12 and 24 dB steps of external gain. The lower bits act as a fine-grained filter: several small moves must add up before the external gain changes.

Two mechanisms move the level. The slow path sums sample magnitudes over integration windows. A chain of four down-counters places those windows inside a repeating time slot: a slot period, a start delay, a window length and a window count. At the end of each window the average is compared with an upper and a lower threshold. The result adds one of three signed deltas: an up step, a down step, or a bias step when the average lies inside the band. The fast path compares every valid sample with an immediate threshold, ignoring the counters. On a hit it applies its own step and then ignores further hits for a programmable holdoff.

The 3-bit gain code drives a programmable 8-entry lookup table that produces the external control byte. The same code leaves the block as an exponent, so that later stages can compensate the gain.

Top module: `slot_range_ctrl`

## Requirements
- R1: While reset is held and after its release, atten_level is 0, gain_exp is 0 and ext_code equals LUT entry 0.
- R2: At a window decision, an average strictly above cfg_thr_hi adds cfg_step_up and an average strictly below cfg_thr_lo adds cfg_step_dn. Every step is a signed two's complement 8-bit value.
- R3: At a window decision, an average between the thresholds (both inclusive) adds cfg_bias. A bias of 0 leaves the level unchanged.
- R4: The average is the sum of |x| over the 2^cfg_win_log2 clocks of a window, shifted right by cfg_win_log2. A clock without smp_valid contributes zero. smp_data is two's complement, and the magnitude of a negative sample is its negation.
- R5: A slot repeats every cfg_slot_len clocks. Integration starts cfg_start_dly+1 clocks after the slot start. cfg_win_count back-to-back windows follow, each giving exactly one decision, and the level moves about two clocks after a window closes.
- R6: A sync_pulse restarts the slot on the next clock, discards any partial window and produces no decision in the following cycle.
- R7: A valid sample whose magnitude exceeds cfg_thr_imm adds cfg_step_imm to the level at the next edge, regardless of the slot counters, provided no holdoff is running.
- R8: After an immediate hit, further hits are ignored for cfg_holdoff clocks, so hits under a steady overload are spaced cfg_holdoff+1 clocks apart.
- R9: When an immediate hit and a window decision fall in the same cycle, only the immediate step is applied and the window result is dropped.
- R10: Every update is computed without wrap and clamped to [cfg_lim_lo, cfg_lim_hi]. A level that leaves the range is pulled back to the nearer limit.
- R11: gain_exp is atten_level[7:5]. ext_code is cfg_code_lut[8*g+7 : 8*g], where g is gain_exp.
- R12: atten_level changes only after a window decision or an immediate hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | ADC mantissa, two's complement |
| sync_pulse | input | 1 | Slot restart pulse |
| cfg_slot_len | input | 16 | Slot period in clocks |
| cfg_start_dly | input | 16 | Clocks from slot start to integration, minus one |
| cfg_win_log2 | input | 4 | log2 of window length in clocks (at most 15) |
| cfg_win_count | input | 8 | Windows per slot (0 is treated as 1) |
| cfg_thr_hi | input | 16 | Upper average threshold |
| cfg_thr_lo | input | 16 | Lower average threshold |
| cfg_thr_imm | input | 16 | Per-sample immediate threshold |
| cfg_step_up | input | 8 | Signed step when average is high |
| cfg_step_dn | input | 8 | Signed step when average is low |
| cfg_step_imm | input | 8 | Signed step on immediate hit |
| cfg_bias | input | 8 | Signed step when average is in band |
| cfg_lim_hi | input | 8 | Upper clamp for the level |
| cfg_lim_lo | input | 8 | Lower clamp for the level |
| cfg_holdoff | input | 16 | Clocks the immediate check stays disarmed |
| cfg_code_lut | input | 64 | Eight 8-bit external codes, entry g at bits 8g+7:8g |
| ext_code | output | 8 | External attenuator or VGA control byte |
| gain_exp | output | 3 | Gain code for downstream compensation |
| atten_level | output | 8 | Current attenuation level |

## Verification
A corrupted slot or window counter shows up at atten_level as decisions that are missing, extra or shifted. With a constant input every window gives a known step, so the error shows within one slot as a wrong count of level changes. A wrong accumulator or magnitude selects the wrong delta at the next window end, one window length later. A stuck holdoff counter changes the spacing of immediate hits within cfg_holdoff+1 clocks, and an arbitration or clamping fault shows as a jump larger than the expected step or a level outside the limits on the very next update.

// File: rtl/srange_pkg.sv
package srange_pkg;

    // Position of the slot timer inside one slot.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DELAY = 2'd1,
        PH_INTEG = 2'd2
    } phase_e;

endpackage

// File: rtl/slot_timer.sv
module slot_timer
    import srange_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int WCNT_W = 8,
    parameter int LOG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic [CNT_W-1:0]  slot_len,
    input  logic [CNT_W-1:0]  start_dly,
    input  logic [LOG_W-1:0]  win_log2,
    input  logic [WCNT_W-1:0] win_count,
    output logic              restart_o,
    output logic              integ_o,
    output logic              win_end_o
);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   slot;
        logic [CNT_W-1:0]   dly;
        logic [CNT_W-1:0]   len;
        logic [WCNT_W-1:0]  wleft;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [CNT_W-1:0] win_last;

    always_comb begin
        tmr_d     = tmr_q;
        win_last  = (CNT_W'(1) << win_log2) - CNT_W'(1);
        restart_o = sync_i || (tmr_q.slot == '0);
        integ_o   = (tmr_q.phase == PH_INTEG);
        win_end_o = integ_o && (tmr_q.len == '0) && !restart_o;

        if (restart_o) begin
            tmr_d.slot  = slot_len - CNT_W'(1);
            tmr_d.phase = PH_DELAY;
            tmr_d.dly   = start_dly;
        end else begin
            tmr_d.slot = tmr_q.slot - CNT_W'(1);
            case (tmr_q.phase)
                PH_DELAY: begin
                    if (tmr_q.dly == '0) begin
                        tmr_d.phase = PH_INTEG;
                        tmr_d.len   = win_last;
                        tmr_d.wleft = (win_count == '0) ? '0 : win_count - WCNT_W'(1);
                    end else begin
                        tmr_d.dly = tmr_q.dly - CNT_W'(1);
                    end
                end
                PH_INTEG: begin
                    if (tmr_q.len == '0) begin
                        if (tmr_q.wleft == '0) begin
                            tmr_d.phase = PH_IDLE;
                        end else begin
                            tmr_d.wleft = tmr_q.wleft - WCNT_W'(1);
                            tmr_d.len   = win_last;
                        end
                    end else begin
                        tmr_d.len = tmr_q.len - CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '{phase: PH_IDLE, default: '0};
        else        tmr_q <= tmr_d;
    end

endmodule

// File: rtl/mag_integrator.sv
module mag_integrator #(
    parameter int SMP_W = 16,
    parameter int LOG_W = 4,
    parameter int ACC_W = SMP_W + (1 << LOG_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             integ_i,
    input  logic             end_i,
    input  logic             valid_i,
    input  logic [SMP_W-1:0] data_i,
    input  logic [LOG_W-1:0] win_log2,
    output logic [SMP_W-1:0] mag_o,
    output logic [ACC_W-1:0] avg_o,
    output logic             avg_vld_o
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] avg;
        logic             vld;
    } int_t;

    int_t int_d, int_q;
    logic [ACC_W-1:0] add, sum;

    always_comb begin
        int_d = int_q;
        mag_o = data_i[SMP_W-1] ? (~data_i + SMP_W'(1)) : data_i;
        add   = (integ_i && valid_i) ? {{(ACC_W-SMP_W){1'b0}}, mag_o} : '0;
        sum   = int_q.acc + add;
        int_d.vld = 1'b0;
        if (clear_i) begin
            int_d.acc = '0;
        end else if (end_i) begin
            int_d.acc = '0;
            int_d.avg = sum >> win_log2;
            int_d.vld = 1'b1;
        end else if (integ_i) begin
            int_d.acc = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) int_q <= '0;
        else        int_q <= int_d;
    end

    assign avg_o     = int_q.avg;
    assign avg_vld_o = int_q.vld;

endmodule

// File: rtl/code_map.sv
module code_map #(
    parameter int SEL_W  = 3,
    parameter int CODE_W = 8
) (
    input  logic [(1<<SEL_W)*CODE_W-1:0] lut_i,
    input  logic [SEL_W-1:0]             sel_i,
    output logic [CODE_W-1:0]            code_o
);

    localparam int N_ENT = 1 << SEL_W;

    logic [CODE_W-1:0] tbl [N_ENT];

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        assign tbl[i] = lut_i[i*CODE_W +: CODE_W];
    end

    assign code_o = tbl[sel_i];

endmodule

// File: rtl/slot_range_ctrl.sv
module slot_range_ctrl #(
    parameter int SMP_W  = 16,
    parameter int CNT_W  = 16,
    parameter int WCNT_W = 8,
    parameter int LOG_W  = 4,
    parameter int ATT_W  = 8,
    parameter int EXP_W  = 3,
    parameter int CODE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          smp_valid,
    input  logic [SMP_W-1:0]              smp_data,
    input  logic                          sync_pulse,
    input  logic [CNT_W-1:0]              cfg_slot_len,
    input  logic [CNT_W-1:0]              cfg_start_dly,
    input  logic [LOG_W-1:0]              cfg_win_log2,
    input  logic [WCNT_W-1:0]             cfg_win_count,
    input  logic [SMP_W-1:0]              cfg_thr_hi,
    input  logic [SMP_W-1:0]              cfg_thr_lo,
    input  logic [SMP_W-1:0]              cfg_thr_imm,
    input  logic [ATT_W-1:0]              cfg_step_up,
    input  logic [ATT_W-1:0]              cfg_step_dn,
    input  logic [ATT_W-1:0]              cfg_step_imm,
    input  logic [ATT_W-1:0]              cfg_bias,
    input  logic [ATT_W-1:0]              cfg_lim_hi,
    input  logic [ATT_W-1:0]              cfg_lim_lo,
    input  logic [CNT_W-1:0]              cfg_holdoff,
    input  logic [(1<<EXP_W)*CODE_W-1:0]  cfg_code_lut,
    output logic [CODE_W-1:0]             ext_code,
    output logic [EXP_W-1:0]              gain_exp,
    output logic [ATT_W-1:0]              atten_level
);

    localparam int ACC_W = SMP_W + (1 << LOG_W) - 1;
    localparam int SUM_W = ATT_W + 2;

    logic             restart, integ, win_end, avg_vld, imm_hit;
    logic [SMP_W-1:0] mag;
    logic [ACC_W-1:0] avg, thr_hi_w, thr_lo_w;
    logic [ATT_W-1:0] delta;
    logic signed [SUM_W-1:0] sum, lo_s, hi_s;

    slot_timer #(.CNT_W(CNT_W), .WCNT_W(WCNT_W), .LOG_W(LOG_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_i    (sync_pulse),
        .slot_len  (cfg_slot_len),
        .start_dly (cfg_start_dly),
        .win_log2  (cfg_win_log2),
        .win_count (cfg_win_count),
        .restart_o (restart),
        .integ_o   (integ),
        .win_end_o (win_end)
    );

    mag_integrator #(.SMP_W(SMP_W), .LOG_W(LOG_W), .ACC_W(ACC_W)) u_integ (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (restart),
        .integ_i   (integ),
        .end_i     (win_end),
        .valid_i   (smp_valid),
        .data_i    (smp_data),
        .win_log2  (cfg_win_log2),
        .mag_o     (mag),
        .avg_o     (avg),
        .avg_vld_o (avg_vld)
    );

    typedef struct packed {
        logic [ATT_W-1:0] atten;
        logic [CNT_W-1:0] hold;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d    = ctl_q;
        thr_hi_w = {{(ACC_W-SMP_W){1'b0}}, cfg_thr_hi};
        thr_lo_w = {{(ACC_W-SMP_W){1'b0}}, cfg_thr_lo};
        imm_hit  = smp_valid && (mag > cfg_thr_imm) && (ctl_q.hold == '0);

        // Immediate hit wins over a window decision in the same cycle.
        if (imm_hit)               delta = cfg_step_imm;
        else if (avg > thr_hi_w)   delta = cfg_step_up;
        else if (avg < thr_lo_w)   delta = cfg_step_dn;
        else                       delta = cfg_bias;

        sum  = $signed({2'b00, ctl_q.atten}) + $signed({{2{delta[ATT_W-1]}}, delta});
        lo_s = $signed({2'b00, cfg_lim_lo});
        hi_s = $signed({2'b00, cfg_lim_hi});

        if (imm_hit || avg_vld) begin
            if (sum < lo_s)      ctl_d.atten = cfg_lim_lo;
            else if (sum > hi_s) ctl_d.atten = cfg_lim_hi;
            else                 ctl_d.atten = sum[ATT_W-1:0];
        end

        if (imm_hit)                 ctl_d.hold = cfg_holdoff;
        else if (ctl_q.hold != '0)   ctl_d.hold = ctl_q.hold - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign atten_level = ctl_q.atten;
    assign gain_exp    = ctl_q.atten[ATT_W-1 -: EXP_W];

    code_map #(.SEL_W(EXP_W), .CODE_W(CODE_W)) u_map (
        .lut_i  (cfg_code_lut),
        .sel_i  (gain_exp),
        .code_o (ext_code)
    );

endmodule

module slot_range_ctrl_chk #(
    parameter int ATT_W = 8,
    parameter int CNT_W = 16,
    parameter int LOG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_pulse,
    input logic [ATT_W-1:0] atten,
    input logic [ATT_W-1:0] lim_lo,
    input logic [ATT_W-1:0] lim_hi,
    input logic             imm_hit,
    input logic             avg_vld,
    input logic [CNT_W-1:0] holdoff,
    input logic [LOG_W-1:0] win_log2
);

    AST_LEVEL_IN_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(atten) |-> (atten >= lim_lo && atten <= lim_hi)); // R10

    AST_CHANGE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(atten) |-> $past(imm_hit || avg_vld)); // R12

    AST_HOLDOFF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_hit && holdoff != '0) |=> !imm_hit); // R8

    AST_SYNC_DROPS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> !avg_vld); // R6

    AST_ONE_DECISION_PER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (avg_vld && win_log2 != '0) |=> !avg_vld); // R5

endmodule

bind slot_range_ctrl slot_range_ctrl_chk #(.ATT_W(ATT_W), .CNT_W(CNT_W), .LOG_W(LOG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_pulse (sync_pulse),
    .atten      (atten_level),
    .lim_lo     (cfg_lim_lo),
    .lim_hi     (cfg_lim_hi),
    .imm_hit    (imm_hit),
    .avg_vld    (avg_vld),
    .holdoff    (cfg_holdoff),
    .win_log2   (cfg_win_log2)
);

// File: tb/slot_range_ctrl_test.sv
`timescale 1ns/1ps
module slot_range_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        sync_pulse = 1'b0;
    logic [15:0] cfg_slot_len, cfg_start_dly, cfg_thr_hi, cfg_thr_lo, cfg_thr_imm, cfg_holdoff;
    logic [3:0]  cfg_win_log2;
    logic [7:0]  cfg_win_count, cfg_step_up, cfg_step_dn, cfg_step_imm, cfg_bias, cfg_lim_hi, cfg_lim_lo;
    logic [63:0] cfg_code_lut;
    logic [7:0]  ext_code, atten_level;
    logic [2:0]  gain_exp;

    int nchecks = 0;
    int nerrs   = 0;
    int exp_q[$];
    string tag_q[$];

    // driver controls
    logic        drv_on = 1'b0;
    logic        drv_half = 1'b0;
    int          drv_left = 0;
    logic [15:0] drv_val = '0;
    int          cyc = 0;

    always #10 clk = ~clk;

    slot_range_ctrl uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .sync_pulse(sync_pulse), .cfg_slot_len(cfg_slot_len), .cfg_start_dly(cfg_start_dly),
        .cfg_win_log2(cfg_win_log2), .cfg_win_count(cfg_win_count), .cfg_thr_hi(cfg_thr_hi),
        .cfg_thr_lo(cfg_thr_lo), .cfg_thr_imm(cfg_thr_imm), .cfg_step_up(cfg_step_up),
        .cfg_step_dn(cfg_step_dn), .cfg_step_imm(cfg_step_imm), .cfg_bias(cfg_bias),
        .cfg_lim_hi(cfg_lim_hi), .cfg_lim_lo(cfg_lim_lo), .cfg_holdoff(cfg_holdoff),
        .cfg_code_lut(cfg_code_lut), .ext_code(ext_code), .gain_exp(gain_exp),
        .atten_level(atten_level)
    );

    function automatic logic [7:0] lut_val(int i);
        return 8'h5A ^ 8'(i * 19);
    endfunction

    task automatic chk(string req, int act, int expv);
        nchecks++;
        if (act != expv) begin
            nerrs++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic push(string req, int v);
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    // Sample driver: inputs change only at the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && drv_left > 0) begin
            smp_valid = 1'b1;
            drv_left--;
        end else begin
            smp_valid = drv_on && (!drv_half || cyc[0]);
        end
        smp_data = drv_val;
    end

    // Monitor: every change of the level must match the next expected item.
    logic [7:0] prev = '0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev = atten_level;
        end else if (atten_level != prev) begin
            if (exp_q.size() == 0) begin
                chk("R12 unexpected level change", int'(atten_level), int'(prev));
            end else begin
                chk(tag_q.pop_front(), int'(atten_level), exp_q.pop_front());
            end
            prev = atten_level;
        end
    end

    task automatic setcfg(int slot, int dly, int wlog, int wcnt, int hi, int lo, int imm,
                          int up, int dn, int bias, int stimm, int lhi, int llo, int hold);
        cfg_slot_len  = 16'(slot);  cfg_start_dly = 16'(dly);
        cfg_win_log2  = 4'(wlog);   cfg_win_count = 8'(wcnt);
        cfg_thr_hi    = 16'(hi);    cfg_thr_lo    = 16'(lo);   cfg_thr_imm = 16'(imm);
        cfg_step_up   = 8'(up);     cfg_step_dn   = 8'(dn);
        cfg_bias      = 8'(bias);   cfg_step_imm  = 8'(stimm);
        cfg_lim_hi    = 8'(lhi);    cfg_lim_lo    = 8'(llo);   cfg_holdoff = 16'(hold);
    endtask

    task automatic start_reset();
        @(negedge clk);
        rst_n = 1'b0; drv_on = 1'b0; drv_half = 1'b0; drv_left = 0; sync_pulse = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic release_reset();
        rst_n = 1'b1;
    endtask

    task automatic drained(string req);
        chk(req, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    initial begin
        for (int i = 0; i < 8; i++) cfg_code_lut[i*8 +: 8] = lut_val(i);
        setcfg(64, 3, 3, 4, 4000, 1000, 16'hFFFF, 40, -40, 0, 0, 100, 0, 0);

        // T0: reset state (R1)
        start_reset();
        chk("R1 level in reset", int'(atten_level), 0);
        chk("R1 exponent in reset", int'(gain_exp), 0);
        chk("R1 code in reset", int'(ext_code), int'(lut_val(0)));

        // T1: negative samples above upper threshold, saturation at upper limit (R2 R4 R10 R11)
        drv_val = 16'(-5000); drv_on = 1'b1;
        push("R2 step up", 40); push("R2 step up", 80); push("R10 clamp high", 100);
        release_reset();
        @(negedge clk);
        chk("R1 level after release", int'(atten_level), 0);
        repeat (150) @(negedge clk);
        chk("R10 held at upper limit", int'(atten_level), 100);
        chk("R11 exponent", int'(gain_exp), 3);
        chk("R11 code", int'(ext_code), int'(lut_val(3)));
        drained("R5 decisions T1");

        // T2: lower limit pull-up, then below-threshold steps (R2 R10 R11)
        start_reset();
        setcfg(64, 3, 3, 4, 4000, 1000, 16'hFFFF, 40, -40, 0, 0, 200, 70, 0);
        drv_val = 16'd5000; drv_on = 1'b1;
        push("R10 clamp low", 70); push("R2 step up", 110); push("R2 step up", 150);
        push("R2 step up", 190); push("R2 step down", 150); push("R2 step down", 110);
        push("R2 step down", 70);
        release_reset();
        repeat (50) @(negedge clk);
        chk("R11 exponent mid", int'(gain_exp), 5);
        drv_val = 16'd300;
        repeat (70) @(negedge clk);
        chk("R10 held at lower limit", int'(atten_level), 70);
        chk("R11 code low", int'(ext_code), int'(lut_val(2)));
        drained("R5 decisions T2");

        // T3: half-duty samples average in band, bias applied, 2 windows of 16 (R3 R4 R5)
        start_reset();
        setcfg(64, 3, 4, 2, 4000, 1000, 16'hFFFF, 40, -40, 3, 0, 255, 0, 0);
        drv_val = 16'(-6000); drv_on = 1'b1; drv_half = 1'b1;
        push("R3 bias", 3); push("R3 bias", 6); push("R4 halved average", 9); push("R3 bias", 12);
        release_reset();
        repeat (120) @(negedge clk);
        chk("R4 level after two slots", int'(atten_level), 12);
        drained("R5 decisions T3");

        // T4: start delay and sync restart (R5 R6 R12)
        start_reset();
        setcfg(1000, 40, 3, 1, 4000, 1000, 16'hFFFF, 40, -40, 0, 0, 255, 0, 0);
        drv_val = 16'd5000; drv_on = 1'b1;
        push("R5 first decision", 40);
        release_reset();
        repeat (30) @(negedge clk);
        chk("R5 no decision during start delay", int'(atten_level), 0);
        repeat (40) @(negedge clk);
        chk("R5 decision after delay", int'(atten_level), 40);
        push("R6 decision after sync", 80);
        repeat (30) @(negedge clk);
        sync_pulse = 1'b1;
        @(negedge clk);
        sync_pulse = 1'b0;
        repeat (40) @(negedge clk);
        chk("R12 level idle after slot windows", int'(atten_level), 40);
        repeat (60) @(negedge clk);
        chk("R6 sync produced new slot", int'(atten_level), 80);
        drained("R6 decisions T4");

        // T5: immediate hits with holdoff 9 over a 25-sample burst (R7 R8 R3 R12)
        start_reset();
        setcfg(64, 3, 3, 4, 16'hFFFF, 0, 3000, 40, -40, 0, 2, 255, 0, 9);
        drv_val = 16'd5000; drv_left = 25;
        push("R7 immediate hit", 2); push("R8 hit after holdoff", 4); push("R8 hit after holdoff", 6);
        release_reset();
        repeat (60) @(negedge clk);
        chk("R8 three hits in burst", int'(atten_level), 6);
        repeat (100) @(negedge clk);
        chk("R3 zero bias keeps level", int'(atten_level), 6);
        drained("R8 decisions T5");

        // T6: immediate every clock overrides window decisions (R9 R10)
        start_reset();
        setcfg(64, 3, 3, 4, 4000, 1000, 3000, 16, -40, 0, 1, 60, 0, 0);
        drv_val = 16'd5000; drv_on = 1'b1;
        for (int v = 1; v <= 60; v++) push("R9 immediate priority", v);
        release_reset();
        repeat (200) @(negedge clk);
        chk("R9 final level at limit", int'(atten_level), 60);
        drained("R9 decisions T6");

        $display("CHECKS %0d ERRORS %0d", nchecks, nerrs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchecks++;
        nerrs++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchecks, nerrs);
        $finish;
    end

endmodule